// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire (I2C) link in front of a small byte-wide storage array. It watches the clock and data lines, which arrive as plain logic levels from an open-drain bus. A master selects the slave by sending its 7-bit device address, loads an internal word pointer, and then writes one byte or streams bytes back out. A write does not reach the array until the STOP that closes the transfer. That STOP starts a timed programming interval, and during it the slave ignores the bus entirely.

The block drives the data line only as an active-low pull-down enable. The surrounding pad logic turns that enable into the open-drain output. The `busy` output shows when the programming interval is running. Storage is a register array held inside the block.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe` and `busy` are 0, the word pointer is 0 and every storage byte reads 0.
- R2: After a START, the first byte is taken as a 7-bit device address sent MSB first, followed by the direction bit (1 = read). The slave pulls SDA low for the ninth clock only when the address equals `DEV_ADDR` (default 7'b1010000). Otherwise it keeps SDA released until the next START.
- R3: In a write transfer the slave acknowledges the word-address byte and loads it into the pointer, then acknowledges one data byte. Any further byte in the same transfer gets no acknowledge and does not replace the held data byte.
- R4: A STOP that follows an acknowledged data byte stores that byte at the pointer location. `busy` is then high for exactly `PROG_CYCLES` clocks, starting on the clock after the STOP is seen.
- R5: While `busy` is high, the slave never pulls SDA low, including for its own address, and bus traffic has no effect on storage or on the pointer.
- R6: In a read transfer the slave sends the byte at the pointer MSB first, one bit per clock, then releases SDA for the ninth clock. The pointer advances by one after each sent byte and wraps from the top address to 0. If the master pulls SDA low on the ninth clock, the next byte follows.
- R7: If the master leaves SDA high on the ninth clock of a read, the slave releases SDA and stays released until the next START or STOP.
- R8: A repeated START with the read bit set, sent after a word address, reads from that address. A read transfer that sends no word address continues from the current pointer.
- R9: A START or STOP seen at any point in a transfer ends it. A partly received data byte, or a transfer that stops after only the word address, writes nothing and starts no programming interval.
- R10: `sda_oe` changes only on the clock after a falling SCL edge is detected, so the slave never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen at the pin |
| sda_i | input | 1 | Bus data level as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| busy | output | 1 | Programming interval in progress |

## Verification
The bench goes after these corner cases:

- **Address sent during the programming interval.** A design that forgot the deaf window would acknowledge its own address there, or accept a new word address.
- **Sequential read past the top address.** A pointer of the wrong width, or one that advances at the wrong moment, shows up as a repeated or skipped byte at the wrap.
- **A START partway through the data byte.** A design that commits early would write garbage and raise `busy`.
- **A third byte after the data byte.** A design that loses track of its count would acknowledge that byte or overwrite the held data.
- **Clocking after a not-acknowledged read.** This catches a slave that keeps driving SDA once the master has declined more data.
- **Length of `busy`.** Counting `busy` cycle by cycle catches an off-by-one in the countdown.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_ACK,
      ST_WADDR,
      ST_WDATA,
      ST_TX,
      ST_RACK,
      ST_IGN
   } slv_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   if (STAGES < 1) begin : g_bad_stages
      $error("i2c_bus_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;
   logic              sda_s;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[0] <= 1'b1;
               sda_pipe[0] <= 1'b1;
            end else begin
               scl_pipe[0] <= scl_i;
               sda_pipe[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_pipe[g] <= 1'b1;
               sda_pipe[g] <= 1'b1;
            end else begin
               scl_pipe[g] <= scl_pipe[g-1];
               sda_pipe[g] <= sda_pipe[g-1];
            end
         end
      end
   end

   assign scl_s = scl_pipe[STAGES-1];
   assign sda_s = sda_pipe[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign sda_lvl   = sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_prog_timer.sv
module i2c_prog_timer #(
   parameter int PROG_CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);

   localparam int CNT_W = $clog2(PROG_CYCLES + 1);

   if (PROG_CYCLES < 1) begin : g_bad_len
      $error("i2c_prog_timer: PROG_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (kick) begin
         remain <= CNT_W'(PROG_CYCLES);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy = (remain != '0);

   // R4
   kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> busy);

endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            cells[i] <= '0;
         end
      end else if (wr_en) begin
         cells[addr] <= wr_data;
      end
   end

   assign rd_data = cells[addr];

endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
   import i2c_mem_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1010000,
   parameter int         ADDR_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_lvl,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_evt,
   input  logic               stop_evt,
   input  logic               busy,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic               sda_oe,
   output logic               wr_en,
   output logic [ADDR_W-1:0]  ptr,
   output logic [BYTE_W-1:0]  wr_data
);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
      $error("i2c_mem_ctrl: ADDR_W must be between 1 and 8");
   end

   slv_state_t        state;
   slv_state_t        after_ack;
   logic [BYTE_W-1:0] sr;
   logic [2:0]        bcnt;
   logic              byte_rdy;
   logic              wr_pend;
   logic              mack;
   logic              rx_state;

   assign rx_state = (state == ST_DEV) || (state == ST_WADDR) || (state == ST_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         after_ack <= ST_IDLE;
         sr        <= '0;
         bcnt      <= '0;
         byte_rdy  <= 1'b0;
         wr_pend   <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
         wr_en     <= 1'b0;
         ptr       <= '0;
         wr_data   <= '0;
      end else begin
         wr_en <= 1'b0;
         if (busy) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            byte_rdy <= 1'b0;
            wr_pend  <= 1'b0;
         end else if (stop_evt) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            byte_rdy <= 1'b0;
            wr_pend  <= 1'b0;
            wr_en    <= wr_pend;
         end else if (start_evt) begin
            state    <= ST_DEV;
            sda_oe   <= 1'b0;
            byte_rdy <= 1'b0;
            wr_pend  <= 1'b0;
            bcnt     <= '0;
         end else if (rx_state) begin
            if (scl_rise && !byte_rdy) begin
               sr   <= {sr[BYTE_W-2:0], sda_lvl};
               bcnt <= bcnt + 1'b1;
               if (bcnt == 3'd7) begin
                  byte_rdy <= 1'b1;
               end
            end else if (scl_fall && byte_rdy) begin
               byte_rdy <= 1'b0;
               unique case (state)
                  ST_DEV: begin
                     if (sr[7:1] == DEV_ADDR) begin
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= sr[0] ? ST_TX : ST_WADDR;
                     end else begin
                        state <= ST_IGN;
                     end
                  end
                  ST_WADDR: begin
                     ptr       <= sr[ADDR_W-1:0];
                     sda_oe    <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_WDATA;
                  end
                  default: begin
                     wr_data   <= sr;
                     wr_pend   <= 1'b1;
                     sda_oe    <= 1'b1;
                     state     <= ST_ACK;
                     after_ack <= ST_IGN;
                  end
               endcase
            end
         end else begin
            unique case (state)
               ST_ACK: begin
                  if (scl_fall) begin
                     bcnt  <= '0;
                     state <= after_ack;
                     if (after_ack == ST_TX) begin
                        sr     <= rd_data;
                        sda_oe <= ~rd_data[7];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bcnt <= bcnt + 1'b1;
                     if (bcnt == 3'd7) begin
                        byte_rdy <= 1'b1;
                     end
                  end else if (scl_fall) begin
                     if (byte_rdy) begin
                        byte_rdy <= 1'b0;
                        sda_oe   <= 1'b0;
                        ptr      <= ptr + 1'b1;
                        state    <= ST_RACK;
                     end else begin
                        sr     <= {sr[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~sr[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        sr     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        bcnt   <= '0;
                        state  <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_IGN;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

   // R10
   oe_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall));

   // R5
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R7
   ign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGN) |-> !sda_oe);

   // R9
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && !busy && !stop_evt) |=> (state == ST_DEV) && !wr_pend);

   // R2
   addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_DEV && state == ST_ACK) |-> ($past(sr[7:1]) == DEV_ADDR));

endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1010000,
   parameter int         ADDR_W      = 8,
   parameter int         PROG_CYCLES = 2000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   output logic busy
);

   logic              sda_lvl;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_evt;
   logic              stop_evt;
   logic              wr_en;
   logic [ADDR_W-1:0] ptr;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_data;

   i2c_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   i2c_mem_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .busy      (busy),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe),
      .wr_en     (wr_en),
      .ptr       (ptr),
      .wr_data   (wr_data)
   );

   i2c_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (wr_en),
      .busy  (busy)
   );

   i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) mem_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (ptr),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

endmodule

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;

   localparam int PROG = 300;
   localparam int H    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic busy;
   logic sda_line;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_mem [256];
   logic [7:0] exp_ptr = 8'h00;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_mem_slave #(
      .DEV_ADDR    (7'b1010000),
      .ADDR_W      (8),
      .PROG_CYCLES (PROG),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_m),
      .sda_i  (sda_line),
      .sda_oe (sda_oe),
      .busy   (busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      sda_m = 1'b1; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b0; hw(H);
   endtask

   task automatic bstop();
      sda_m = 1'b0; hw(H);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b1;
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; hw(H);
      scl_m = 1'b1; hw(H);
      s = sda_line;
      scl_m = 1'b0; hw(H);
   endtask

   task automatic write_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         clk_bit(1'b1, s);
         b = {b[6:0], s};
      end
      clk_bit(~give_ack, s);
      sda_m = 1'b1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < PROG + 100 && busy; i++) hw(1);
      hw(H);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit probe);
      logic ack;
      int cnt;
      bstart();
      write_byte(8'hA0, ack); chk("R2 write address ack", ack, 1);
      write_byte(a, ack);     chk("R3 word address ack", ack, 1);
      write_byte(d, ack);     chk("R3 data ack", ack, 1);
      bstop();
      if (probe) begin
         hw(4);
         chk("R4 busy after stop", busy, 1);
         bstart();
         write_byte(8'hA0, ack); chk("R5 no ack while busy", ack, 0);
         write_byte(8'h00, ack); chk("R5 no ack on byte while busy", ack, 0);
         bstop();
         hw(H);
         wait_idle();
      end else begin
         cnt = 0;
         for (int i = 0; i < PROG + 40; i++) begin
            hw(1);
            if (busy) cnt++;
         end
         chk("R4 busy length", cnt, PROG);
      end
      exp_mem[a] = d;
      exp_ptr = a;
   endtask

   task automatic rand_read(input logic [7:0] a, input int n);
      logic ack;
      logic [7:0] b;
      bstart();
      write_byte(8'hA0, ack); chk("R8 address ack", ack, 1);
      write_byte(a, ack);     chk("R8 word address ack", ack, 1);
      bstart();
      write_byte(8'hA1, ack); chk("R8 read address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, b);
         chk("R6 read data", b, exp_mem[8'(a + i)]);
      end
      bstop(); hw(H);
      exp_ptr = 8'(a + n);
   endtask

   task automatic cur_read(input int n);
      logic ack;
      logic [7:0] b;
      bstart();
      write_byte(8'hA1, ack); chk("R8 current read ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         read_byte(i != n - 1, b);
         chk("R8 current read data", b, exp_mem[8'(exp_ptr + i)]);
      end
      bstop(); hw(H);
      exp_ptr = 8'(exp_ptr + n);
   endtask

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=expired expected=done");
      finish_up();
   end

   initial begin
      logic ack;
      logic [7:0] b;
      logic s;
      void'($urandom(32'h5eed1234));
      for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
      hw(5);
      chk("R1 sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      hw(H);
      chk("R1 sda_oe after reset", sda_oe, 0);
      chk("R1 busy after reset", busy, 0);
      cur_read(2);

      // R2: foreign addresses get no ack and SDA stays released
      bstart();
      write_byte(8'hA2, ack); chk("R2 foreign write address nack", ack, 0);
      read_byte(1'b0, b);     chk("R2 released after foreign address", b, 8'hFF);
      bstop(); hw(H);
      bstart();
      write_byte(8'hB1, ack); chk("R2 foreign read address nack", ack, 0);
      bstop(); hw(H);

      // R3 R4 plain write, then R5 probe during programming
      do_write(8'h10, 8'h5A, 1'b0);
      do_write(8'h11, 8'hC3, 1'b1);
      rand_read(8'h10, 2);

      // R6 wrap of the pointer
      do_write(8'hFF, 8'h77, 1'b0);
      do_write(8'h00, 8'h34, 1'b0);
      rand_read(8'hFF, 3);
      cur_read(1);

      // R7 no drive after master nack
      bstart();
      write_byte(8'hA1, ack); chk("R7 address ack", ack, 1);
      read_byte(1'b0, b);     chk("R7 first byte", b, exp_mem[exp_ptr]);
      exp_ptr = 8'(exp_ptr + 1);
      read_byte(1'b0, b);     chk("R7 line released after nack", b, 8'hFF);
      bstop(); hw(H);

      // R3 extra byte after data not acknowledged
      bstart();
      write_byte(8'hA0, ack); chk("R3 address ack", ack, 1);
      write_byte(8'h40, ack); chk("R3 word address ack", ack, 1);
      write_byte(8'h99, ack); chk("R3 data ack", ack, 1);
      write_byte(8'h66, ack); chk("R3 extra byte nack", ack, 0);
      bstop(); hw(H);
      chk("R4 busy after write", busy, 1);
      wait_idle();
      exp_mem[8'h40] = 8'h99;
      exp_ptr = 8'h40;
      rand_read(8'h40, 2);

      // R9 start in middle of data byte aborts the write
      bstart();
      write_byte(8'hA0, ack); chk("R9 address ack", ack, 1);
      write_byte(8'h20, ack); chk("R9 word address ack", ack, 1);
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
      bstart();
      write_byte(8'hA1, ack); chk("R9 restart accepted", ack, 1);
      read_byte(1'b0, b);     chk("R9 aborted byte not stored", b, 8'h00);
      bstop(); hw(H);
      chk("R9 no programming after abort", busy, 0);
      exp_ptr = 8'h21;

      // R9 stop right after word address
      bstart();
      write_byte(8'hA0, ack); chk("R9 address ack", ack, 1);
      write_byte(8'h30, ack); chk("R9 word address ack", ack, 1);
      bstop(); hw(H);
      chk("R9 no programming without data", busy, 0);
      exp_ptr = 8'h30;
      cur_read(1);

      // random mix
      for (int it = 0; it < 30; it++) begin
         int op;
         op = $urandom_range(0, 2);
         if (op == 0) do_write(8'($urandom), 8'($urandom), 1'b0);
         else if (op == 1) rand_read(8'($urandom), $urandom_range(1, 4));
         else cur_read($urandom_range(1, 3));
      end

      finish_up();
   end

endmodule